// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block sequences trace triggering for an on-chip debug unit. Four comparator channels, numbered 0 to 3, send single-cycle match pulses. Each pulse counts only when the enable bit for that channel is set. The sequencer leaves idle when its arm input rises. It then steps through a first, second and third stage and ends in a final stage, where it fires a trigger.

In the first stage, a 4-bit selection code chooses one of sixteen transition maps. That code sits in the low nibble of an 8-bit control register. The register can be read at any time. Writes to it are refused while the sequencer is armed. When several enabled matches arrive in the same cycle, the lowest channel wins. A match that leads to the final stage overrides all the others. In the second and third stages, any enabled match ends the sequence.

Reaching the final stage does three things: it raises a one-cycle trigger, it sets a sticky done flag, and it disarms the block. Software restarts the sequencer by dropping the arm input and raising it again.

Top module: `trig_seq`

## Requirements
- R1: After reset the state output is 0 (idle), and reg_rdata_o, trig_o, done_o and armed_o are all 0.
- R2: reg_rdata_o always shows the selection code in bits 3:0, with bits 7:4 reading as zero. A write takes effect at the next clock edge when the block is not armed.
- R3: A write made while armed_o is 1 (state 1, 2 or 3) has no effect on the register.
- R4: A rising edge on arm_i moves the state to 1 at the next edge and clears done_o. Whenever arm_i is low, the state is 0 at the next edge.
- R5: A match on a channel whose cmp_en_i bit is 0 has no effect.
- R6: State encoding: 0 idle, 1 first, 2 second, 3 third, 4 final. In state 1 the code map is:
  - 0001: any channel goes to 2.
  - 0010: any channel goes to 3.
  - 0011: any channel goes to 4.
  - 0100: channels 0 to 2 go to 2.
  - 0101: channel 2 goes to 2.
  - 0110: channel 2 goes to 3.
  - 0111: channel 2 goes to 4.
  - 1000: channel 0 goes to 2 and channel 1 goes to 3.
  - 1001: channel 0 goes to 2 and channel 2 goes to 3.
  - 1010: channel 1 goes to 2 and channel 3 goes to 3.
  - 1011: channel 1 goes to 3 and channel 0 goes to 4.
  - 1100: channel 2 goes to 3 and channel 0 goes to 4.
  - 1101: channel 3 goes to 3 and channel 1 goes to 4.
- R7: In state 1, channels that the code does not name leave the state at 1. Codes 0000, 1110 and 1111 name no channel.
- R8: When several enabled matches occur together in state 1 and none leads to state 4, the lowest-numbered named channel decides the next state.
- R9: If any enabled match in state 1 leads to state 4, the next state is 4, whatever else matches.
- R10: In state 2 or 3, any enabled match moves the state to 4 at the next edge.
- R11: State 4 lasts exactly one cycle, with trig_o equal to 1 during it. done_o is 1 from that cycle on. The state then returns to 0 even if arm_i stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm level; a rising edge starts a sequence |
| cmp_en_i | input | 4 | Per-channel comparator enable |
| match_i | input | 4 | Per-channel match pulses |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| state_o | output | 3 | Current stage (0 idle, 1..3, 4 final) |
| armed_o | output | 1 | High in stages 1 to 3 |
| trig_o | output | 1 | One-cycle trigger pulse in the final stage |
| done_o | output | 1 | Sticky flag, set by the final stage |

## Verification
All of the block's results are registered, so each is due one clock edge after the stimulus that causes it. This covers a match or an arm edge changing state_o, a write reaching reg_rdata_o, and trig_o and done_o rising when state 4 is entered. The return to idle follows one edge after state 4. The bench applies every stimulus at a falling edge and samples at the next falling edge, which puts exactly one rising edge between the two. It also follows a state-4 result with one more sample to check the return to idle.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int N_CH   = 4;
  localparam int CODE_W = 4;
  localparam int REG_W  = 8;
  localparam int ST_W   = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_FIN  = 3'd4
  } seq_st_e;

  // Target of one channel in stage 1 for a given code; ST_IDLE = no effect.
  function automatic seq_st_e chan_target(logic [CODE_W-1:0] code, int ch);
    seq_st_e t;
    t = ST_IDLE;
    case (code)
      4'd1:  t = ST_S2;
      4'd2:  t = ST_S3;
      4'd3:  t = ST_FIN;
      4'd4:  if (ch != 3) t = ST_S2;
      4'd5:  if (ch == 2) t = ST_S2;
      4'd6:  if (ch == 2) t = ST_S3;
      4'd7:  if (ch == 2) t = ST_FIN;
      4'd8:  if (ch == 0) t = ST_S2; else if (ch == 1) t = ST_S3;
      4'd9:  if (ch == 0) t = ST_S2; else if (ch == 2) t = ST_S3;
      4'd10: if (ch == 1) t = ST_S2; else if (ch == 3) t = ST_S3;
      4'd11: if (ch == 1) t = ST_S3; else if (ch == 0) t = ST_FIN;
      4'd12: if (ch == 2) t = ST_S3; else if (ch == 0) t = ST_FIN;
      4'd13: if (ch == 3) t = ST_S3; else if (ch == 1) t = ST_FIN;
      default: t = ST_IDLE;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/trig_sc_reg.sv
module trig_sc_reg
  import trig_seq_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int RW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_i,
  input  logic          we_i,
  input  logic [RW-1:0] wdata_i,
  output logic [CW-1:0] code_o,
  output logic [RW-1:0] rdata_o
);
  logic [CW-1:0] code_q;
  logic          unused_hi;

  assign unused_hi = ^wdata_i[RW-1:CW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             code_q <= '0;
    else if (we_i && !lock_i) code_q <= wdata_i[CW-1:0];
  end

  assign code_o  = code_q;
  assign rdata_o = {{(RW-CW){1'b0}}, code_q};

  a_r3_wr_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(code_q));
  a_r2_wr_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !lock_i) |=> (rdata_o[CW-1:0] == $past(wdata_i[CW-1:0])));
endmodule

// File: rtl/trig_st1_decode.sv
module trig_st1_decode
  import trig_seq_pkg::*;
#(
  parameter int NC = N_CH,
  parameter int CW = CODE_W
) (
  input  logic [CW-1:0] code_i,
  input  logic [NC-1:0] eff_i,
  output seq_st_e       nxt_o
);
  seq_st_e tgt [NC];

  for (genvar g = 0; g < NC; g++) begin : g_tgt
    assign tgt[g] = chan_target(code_i, g);
  end

  always_comb begin
    logic fin_hit;
    nxt_o   = ST_IDLE;
    fin_hit = 1'b0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (eff_i[i] && tgt[i] != ST_IDLE) nxt_o = tgt[i];
      if (eff_i[i] && tgt[i] == ST_FIN)  fin_hit = 1'b1;
    end
    if (fin_hit) nxt_o = ST_FIN;
  end
endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
  import trig_seq_pkg::*;
#(
  parameter int NC = N_CH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [NC-1:0] eff_i,
  input  seq_st_e       dec_i,
  output seq_st_e       st_o,
  output logic          armed_o,
  output logic          trig_o,
  output logic          done_o
);
  seq_st_e st_q, st_d;
  logic    arm_q, done_q;
  logic    arm_rise;

  assign arm_rise = arm_i && !arm_q;

  always_comb begin
    st_d = st_q;
    if (!arm_i)        st_d = ST_IDLE;
    else if (arm_rise) st_d = ST_S1;
    else begin
      case (st_q)
        ST_S1:        if (dec_i != ST_IDLE) st_d = dec_i;
        ST_S2, ST_S3: if (|eff_i) st_d = ST_FIN;
        ST_FIN:       st_d = ST_IDLE;
        default:      st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      arm_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      arm_q <= arm_i;
      if (arm_rise)           done_q <= 1'b0;
      else if (st_d == ST_FIN) done_q <= 1'b1;
    end
  end

  assign st_o    = st_q;
  assign armed_o = (st_q == ST_S1) || (st_q == ST_S2) || (st_q == ST_S3);
  assign trig_o  = (st_q == ST_FIN);
  assign done_o  = done_q;

  a_r4_arm_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_rise |=> (st_q == ST_S1) && !done_q);
  a_r4_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (st_q == ST_IDLE));
  a_r10_late_fin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && arm_q && (st_q == ST_S2 || st_q == ST_S3) && (|eff_i)) |=> (st_q == ST_FIN));
  a_r11_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o && (st_q == ST_IDLE));
  a_r11_done_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> done_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && arm_q && st_q == ST_S1 && eff_i == '0) |=> (st_q == ST_S1));
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [N_CH-1:0]  cmp_en_i,
  input  logic [N_CH-1:0]  match_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic [ST_W-1:0]  state_o,
  output logic             armed_o,
  output logic             trig_o,
  output logic             done_o
);
  logic [CODE_W-1:0] code;
  logic [N_CH-1:0]   eff;
  seq_st_e           dec, st;

  assign eff = match_i & cmp_en_i;

  trig_sc_reg #(.CW(CODE_W), .RW(REG_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (armed_o),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .code_o  (code),
    .rdata_o (reg_rdata_o)
  );

  trig_st1_decode #(.NC(N_CH), .CW(CODE_W)) u_dec (
    .code_i (code),
    .eff_i  (eff),
    .nxt_o  (dec)
  );

  trig_seq_fsm #(.NC(N_CH)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_i),
    .eff_i   (eff),
    .dec_i   (dec),
    .st_o    (st),
    .armed_o (armed_o),
    .trig_o  (trig_o),
    .done_o  (done_o)
  );

  assign state_o = st;

  a_r5_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && arm_i && $past(arm_i) && (match_i & cmp_en_i) == '0)
      |=> (state_o == $past(state_o)));
  a_r9_fin_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && $past(arm_i) && state_o == 3'd1 && dec == ST_FIN) |=> trig_o);
endmodule

// File: tb/tb_trig_seq.sv
`timescale 1ns/1ps
module tb_trig_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 1'b0;
  logic [3:0] en = '0, match = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [2:0] state;
  logic       armed, trig, done;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  trig_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .cmp_en_i(en), .match_i(match),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .state_o(state),
    .armed_o(armed), .trig_o(trig), .done_o(done)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected per-channel target (0 none, 2, 3, 4) from the code table of R6.
  function automatic int ref_tgt(int code, int ch);
    case (code)
      1: return 2;
      2: return 3;
      3: return 4;
      4: return (ch < 3) ? 2 : 0;
      5: return (ch == 2) ? 2 : 0;
      6: return (ch == 2) ? 3 : 0;
      7: return (ch == 2) ? 4 : 0;
      8: return (ch == 0) ? 2 : (ch == 1) ? 3 : 0;
      9: return (ch == 0) ? 2 : (ch == 2) ? 3 : 0;
      10: return (ch == 1) ? 2 : (ch == 3) ? 3 : 0;
      11: return (ch == 0) ? 4 : (ch == 1) ? 3 : 0;
      12: return (ch == 0) ? 4 : (ch == 2) ? 3 : 0;
      13: return (ch == 1) ? 4 : (ch == 3) ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_next(int code, logic [3:0] eff);
    int r = 1;
    for (int c = 3; c >= 0; c--)
      if (eff[c] && ref_tgt(code, c) != 0) r = ref_tgt(code, c);
    for (int c = 0; c < 4; c++)
      if (eff[c] && ref_tgt(code, c) == 4) r = 4;
    return r;
  endfunction

  task automatic trial(int code, logic [3:0] m, logic [3:0] e);
    int exp;
    string tag;
    logic [3:0] eff;
    int k;
    eff = m & e;
    exp = ref_next(code, eff);
    tag = (eff == 0 || exp == 1) ? "R7" : (exp == 4) ? "R9" :
          ($countones(eff) > 1) ? "R8" : "R6";
    if (eff != m) tag = "R5";
    we = 1'b1; wdata = {4'($urandom), 4'(code)};
    @(negedge clk); we = 1'b0;
    chk("R2", rdata, code);
    arm = 1'b1;
    @(negedge clk);
    chk("R4", state, 1); chk("R4", done, 0);
    we = 1'b1; wdata = {4'h0, ~4'(code)};
    @(negedge clk); we = 1'b0;
    chk("R3", rdata, code);
    match = m; en = e;
    @(negedge clk); match = '0;
    chk(tag, state, exp);
    chk(tag, trig, exp == 4);
    if (exp == 2 || exp == 3) begin
      match = 4'hF; en = '0;
      @(negedge clk);
      chk("R5", state, exp);
      k = $urandom_range(0, 3);
      match = 4'(1 << k); en = 4'(1 << k);
      @(negedge clk); match = '0;
      chk("R10", state, 4);
      exp = 4;
    end
    if (exp == 4) begin
      chk("R11", trig, 1); chk("R11", done, 1);
      @(negedge clk);
      chk("R11", state, 0); chk("R11", trig, 0); chk("R11", done, 1);
    end
    arm = 1'b0;
    @(negedge clk);
    chk("R4", state, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    chk("R1", state, 0); chk("R1", rdata, 0); chk("R1", trig, 0);
    chk("R1", done, 0);  chk("R1", armed, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 16; c++)
      for (int m = 1; m < 16; m++)
        trial(c, 4'(m), 4'hF);
    // directed corners: full-priority cases
    trial(11, 4'b0011, 4'hF);  // R9 ch0 to final beats ch1
    trial(13, 4'b1010, 4'hF);  // R9 ch1 final, ch3 third
    trial(8, 4'b0011, 4'b0010); // R5 ch0 masked, ch1 to third
    for (int i = 0; i < 300; i++)
      trial($urandom_range(0, 15), 4'($urandom), 4'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule